// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked on-chip request bus and an external asynchronous static RAM with a 20-bit word address and an 8-bit shared data bus. It turns each single-word read or write request into chip-select, write-enable and output-enable waveforms. Every phase length is derived from a nanosecond minimum and the clock period parameter, so the same RTL meets the memory's timing at any clock rate.

The memory has two chip selects of opposite polarity. The active-low select frames each access. The active-high select stays asserted while the block is awake and is pulled low to park the memory in its low-power retention state when the `sleep` input is high. The shared data pins appear as separate out, enable and in signals, which the pad ring joins into one bidirectional bus.

A requester waits for `ready`, then presents `req` with the operation, address and write data for one cycle. Read results come back on `rd_data` with a one-cycle `rd_valid` pulse.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, with `sleep` low: `ready` is 1, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_cs` is 1, and `mem_dq_oe` and `rd_valid` are 0.
- R2: An accepted read (`req_wr`=0) asserts `mem_cs_n`=0, `mem_cs`=1 and `mem_oe_n`=0 with `mem_we_n`=1, all in the cycle after acceptance. `mem_addr` equals the request address. `mem_oe_n` stays low for RD = max(ceil(55/T), ceil(35/T)) cycles, which is 11 at T=5 ns.
- R3: The value on `mem_dq_in` at the last cycle of the read phase is loaded into `rd_data`. `rd_valid` is high for exactly one cycle, in the cycle in which `mem_oe_n` returns high.
- R4: After a read, `ready` stays low for HZ = ceil(20/T) further cycles (4 at 5 ns), counted from the cycle in which `mem_oe_n` returns high, before the next request can be taken.
- R5: An accepted write (`req_wr`=1) holds `mem_we_n`=0, `mem_cs_n`=0, `mem_cs`=1 and `mem_oe_n`=1 for WR cycles. WR = max(ceil(40/T), ceil(50/T), ceil(55/T), HZ+ceil(25/T)), which is 11 at 5 ns. `mem_addr` is the request address throughout.
- R6: During a write, `mem_dq_oe` stays 0 for the first HZ cycles of the write pulse, then is 1 with `mem_dq_out` equal to the request data until the write ends. It falls in the same cycle as `mem_we_n` rises.
- R7: `ready` is low while an access or its recovery is in progress. A request is accepted only when `req` and `ready` are both 1. A request raised while `ready` is low starts no access and does not change `mem_addr`. `ready` is 1 in the cycle after a write ends.
- R8: When `sleep` is high and the block is idle, `mem_cs` goes to 0 in the next cycle, with `mem_cs_n`, `mem_we_n` and `mem_oe_n` all 1 and `ready` 0. A `sleep` raised during an access does not shorten it, and retention begins one cycle after that access's recovery completes.
- R9: When `sleep` falls, `mem_cs` returns to 1 in the next cycle. `ready` stays low for RC = ceil(55/T) cycles (11 at 5 ns) before the next request can be taken.
- R10: `mem_oe_n` and `mem_we_n` are never low together, and `mem_dq_oe` is 1 only while `mem_we_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep | input | 1 | Request for retention standby |
| req | input | 1 | Access request, taken when ready is high |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 8 | Write data |
| ready | output | 1 | Block can accept a request this cycle |
| rd_data | output | 8 | Captured read data |
| rd_valid | output | 1 | One-cycle pulse, rd_data is new |
| mem_addr | output | 20 | Memory address pins |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select, low in retention |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data received from the memory pins |

## Verification
The memory model in the bench returns valid data only after the output enable has been low for a full access time. A controller that samples one cycle early therefore captures a poison byte, and one that holds the strobe a cycle short produces a wrong phase count. The bench counts each strobe phase, the write-data turnaround and the post-read and wake-up recovery periods. A design that drives the bus too soon, releases `ready` early or skips the retention recovery gives an off-by-some count. Requests are raised while the block is busy and while it is asleep, so a design that accepts them would move the address or assert a strobe where none is allowed. A `sleep` raised in the middle of a read must neither truncate the read nor corrupt its data.

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl #(
  parameter int CLK_NS = 5,
  parameter int T_RC   = 55,
  parameter int T_AA   = 55,
  parameter int T_OE   = 35,
  parameter int T_WC   = 55,
  parameter int T_WP   = 40,
  parameter int T_AW   = 50,
  parameter int T_DW   = 25,
  parameter int T_HZ   = 20,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int HZ_CYC = max2(1, cyc(T_HZ));
  localparam int RD_CYC = max2(1, max2(cyc(T_AA), cyc(T_OE)));
  localparam int WR_CYC = max2(max2(cyc(T_WP), cyc(T_AW)),
                               max2(cyc(T_WC), HZ_CYC + max2(1, cyc(T_DW))));
  localparam int RC_CYC = max2(1, cyc(T_RC));
  localparam int MAX_CYC = max2(max2(HZ_CYC, RD_CYC), max2(WR_CYC, RC_CYC));
  localparam int CNT_W  = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_WRITE, ST_TURN, ST_SLEEP, ST_WAKE} st_t;

  st_t              state;
  logic [CNT_W-1:0] cnt;

  assign ready = (state == ST_IDLE) && !sleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      mem_cs_n   <= 1'b1;
      mem_cs     <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
      case (state)
        ST_IDLE:
          if (req && ready) begin
            mem_addr <= req_addr;
            mem_cs_n <= 1'b0;
            if (req_wr) begin
              state      <= ST_WRITE;
              mem_we_n   <= 1'b0;
              mem_dq_out <= req_wdata;
              cnt        <= CNT_W'(WR_CYC - 1);
            end else begin
              state    <= ST_READ;
              mem_oe_n <= 1'b0;
              cnt      <= CNT_W'(RD_CYC - 1);
            end
          end else if (sleep) begin
            state  <= ST_SLEEP;
            mem_cs <= 1'b0;
          end
        ST_READ:
          if (cnt == '0) begin
            rd_data  <= mem_dq_in;
            rd_valid <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_cs_n <= 1'b1;
            state    <= ST_TURN;
            cnt      <= CNT_W'(HZ_CYC - 1);
          end
        ST_WRITE:
          if (cnt == '0) begin
            mem_we_n  <= 1'b1;
            mem_cs_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            state     <= ST_IDLE;
          end else if (cnt == CNT_W'(WR_CYC - HZ_CYC)) begin
            mem_dq_oe <= 1'b1;
          end
        ST_TURN:
          if (cnt == '0) state <= ST_IDLE;
        ST_SLEEP:
          if (!sleep) begin
            state  <= ST_WAKE;
            mem_cs <= 1'b1;
            cnt    <= CNT_W'(RC_CYC - 1);
          end
        ST_WAKE:
          if (cnt == '0) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: output enable only inside a selected, non-writing read
  a_r2_oe_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_cs_n && mem_cs && mem_we_n));

  // R5: write strobe only while selected with output enable high
  a_r5_we_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_cs && mem_oe_n));

  // R10: bus drive only inside a write pulse
  a_r10_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);

  // R6: no drive in the first cycle of a write pulse
  a_r6_turnaround_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !mem_dq_oe);

  // R3: read valid is a single pulse at the end of the read strobe
  a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  a_r3_valid_at_oe_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(mem_oe_n));

  // R7: an accepted request makes the block busy
  a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready) |=> !ready);

  // R8: retention keeps every other strobe idle
  a_r8_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs |-> (mem_cs_n && mem_we_n && mem_oe_n && !ready));

endmodule

// File: tb/sram_strobe_ctrl_tb.sv
module sram_strobe_ctrl_tb_top;
  localparam int CLK = 5;

  function automatic int cy(input int ns);
    return (ns + CLK - 1) / CLK;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_EXP = mx(cy(55), cy(35));
  localparam int HZ_EXP = cy(20);
  localparam int WR_EXP = mx(mx(cy(40), cy(50)), mx(cy(55), cy(20) + cy(25)));
  localparam int RC_EXP = cy(55);

  logic clk = 0, rst_n = 0, sleep = 0, req = 0, req_wr = 0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic ready, rd_valid, mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rd_data, mem_dq_out, mem_dq_in;
  logic [19:0] mem_addr;

  int total = 0, bad = 0, oe_age = 0;
  logic [7:0] mdl [256];
  logic [7:0] ref_m [256];

  always #(CLK * 500ps) clk = ~clk;

  sram_strobe_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .req(req), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  // memory model: data valid only after a full access time with output enabled
  always @(negedge clk) begin
    if (!mem_oe_n) oe_age <= oe_age + 1; else oe_age <= 0;
    if (!mem_we_n && !mem_cs_n && mem_cs && mem_dq_oe) mdl[mem_addr[7:0]] <= mem_dq_out;
  end
  assign mem_dq_in = (!mem_oe_n && !mem_cs_n && mem_cs && mem_we_n && oe_age >= RD_EXP)
                     ? mdl[mem_addr[7:0]] : 8'hEE;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [19:0] a, input logic [7:0] d);
    int w = 0;
    while (!ready && w < 200) begin w++; @(negedge clk); end
    req = 1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 0;
  endtask

  task automatic do_read(input logic [19:0] a, input bit sl);
    int n = 0;
    issue(0, a, 8'h00);
    if (sl) sleep = 1;
    chk(!mem_cs_n && mem_cs && !mem_oe_n && mem_we_n, "R2 read strobes", {mem_cs_n, mem_cs, mem_oe_n, mem_we_n}, 4'b0101);
    chk(mem_addr == a, "R2 read address", mem_addr, a);
    while (!mem_oe_n && n < 100) begin n++; @(negedge clk); end
    chk(n == RD_EXP, "R2/R10 read strobe cycles", n, RD_EXP);
    chk(rd_valid, "R3 valid pulse", rd_valid, 1);
    chk(rd_data == ref_m[a[7:0]], "R3 read data", rd_data, ref_m[a[7:0]]);
    chk(mem_cs_n, "R2 deselect after read", mem_cs_n, 1);
    n = 0;
    if (sl) begin
      while (mem_cs && n < 100) begin n++; if (n == 2) chk(!rd_valid, "R3 pulse width", rd_valid, 0); @(negedge clk); end
      chk(n == HZ_EXP + 1, "R8 sleep waits for access end", n, HZ_EXP + 1);
    end else begin
      while (!ready && n < 100) begin n++; if (n == 2) chk(!rd_valid, "R3 pulse width", rd_valid, 0); @(negedge clk); end
      chk(n == HZ_EXP, "R4 read turnaround", n, HZ_EXP);
    end
  endtask

  task automatic do_write(input logic [19:0] a, input logic [7:0] d);
    int n = 0, first = -1, wrong = 0;
    issue(1, a, d);
    ref_m[a[7:0]] = d;
    chk(!mem_we_n && !mem_cs_n && mem_cs && mem_oe_n && mem_addr == a, "R5 write strobes",
        {mem_we_n, mem_cs_n, mem_cs, mem_oe_n}, 4'b0011);
    while (!mem_we_n && n < 100) begin
      if (mem_dq_oe && first < 0) first = n;
      if (mem_dq_oe && mem_dq_out != d) wrong++;
      if (mem_addr != a) wrong++;
      n++;
      @(negedge clk);
    end
    chk(n == WR_EXP, "R5/R10 write pulse cycles", n, WR_EXP);
    chk(first == HZ_EXP, "R6 drive start cycle", first, HZ_EXP);
    chk(wrong == 0, "R6 write data and address stable", wrong, 0);
    chk(!mem_dq_oe, "R6 drive ends with write", mem_dq_oe, 0);
    chk(ready, "R7 ready after write", ready, 1);
  endtask

  task automatic wake_check();
    int n = 0;
    sleep = 0;
    @(negedge clk);
    chk(mem_cs, "R9 chip select back", mem_cs, 1);
    while (!ready && n < 100) begin n++; @(negedge clk); end
    chk(n == RC_EXP, "R9 wake recovery cycles", n, RC_EXP);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < 256; i++) begin mdl[i] = 8'(i) ^ 8'h5A; ref_m[i] = 8'(i) ^ 8'h5A; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ready && mem_cs_n && mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid,
        "R1 reset state", {ready, mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid}, 7'b1111100);

    do_read(20'h00012, 0);
    do_write(20'hABC12, 8'hC3);
    do_read(20'h00012, 0);
    do_write(20'hFFFFF, 8'h00);
    do_read(20'hFFFFF, 0);

    // R7: request while busy is ignored
    fork
      do_write(20'h12345, 8'h77);
      begin
        repeat (3) @(negedge clk);
        req = 1; req_wr = 0; req_addr = 20'h54321;
        repeat (4) @(negedge clk);
        req = 0;
      end
    join
    for (int k = 0; k < 3; k++) begin
      chk(mem_cs_n && mem_oe_n && mem_addr == 20'h12345, "R7 busy request ignored", mem_addr, 20'h12345);
      @(negedge clk);
    end

    // R8/R9: standby entry, requests ignored while asleep, recovery
    sleep = 1;
    @(negedge clk);
    chk(!mem_cs && mem_cs_n && !ready, "R8 standby entry", {mem_cs, mem_cs_n, ready}, 3'b010);
    req = 1; req_wr = 1; req_addr = 20'h00099; req_wdata = 8'h11;
    repeat (4) @(negedge clk);
    chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_cs, "R8 asleep no access", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
    req = 0;
    wake_check();

    // R8: sleep raised during a read
    do_read(20'h00040, 1);
    chk(!mem_cs && !ready, "R8 standby after access", {mem_cs, ready}, 0);
    wake_check();

    for (int i = 0; i < 60; i++) begin
      logic [19:0] a;
      a = 20'($urandom());
      if (i % 3 == 0) a[7:0] = 8'h12;
      if ($urandom() % 2 == 0) do_write(a, 8'($urandom()));
      else do_read(a, 0);
    end
    do_read(20'hAAA12, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule